// File: doc/BRIEF.md
# Paired Up/Down Event Counter

This block keeps one signed-wrap event count shared by a pair of timer channels: an even channel, which owns the count, and its odd partner. Pairs are formed as 0/1, 2/3, 4/5 and 6/7, and one copy of this block serves one pair. An external edge detector qualifies the input events. The block sees them as one-cycle strobes, `even_evt` and `odd_evt`, and the level of the odd input pin as `odd_level`.

Events are applied once per prescaled tick. Events that arrive between ticks are held until the next tick, so the count moves by at most one step per tick. A two-bit selector picks the counting rule:
- up: even events count up;
- up/down: even events count up and odd events count down, and the two cancel when both arrive in the same tick;
- rotary: an even event counts up or down according to the odd input's level, which makes a quadrature-like decoder.

Wrapping past the top of the range sets a sticky overflow flag, and wrapping below zero sets a sticky underflow flag. Each flag is cleared by a write-1 strobe. An interrupt request is raised while either flag is set and the interrupt enable is high. The selector may only be changed while `enable` is low.

Top module: `paired_event_counter`

## Requirements
- R1: After reset, `count` is 0 and `ovf`, `unf` and `irq` are all 0.
- R2: With `mode` = 2'b01 (up), a tick that has an even event pending makes `count` one larger on that clock edge. Odd events have no effect in this mode.
- R3: With `mode` = 2'b10 (up/down), a tick with only an even event pending adds one to `count`, and a tick with only an odd event pending subtracts one.
- R4: With `mode` = 2'b10, a tick during which both an even and an odd event are pending leaves `count` unchanged. This holds whether the two events arrived in different cycles or in the same cycle.
- R5: With `mode` = 2'b11 (rotary), an even event adds one if `odd_level` was 0 and subtracts one if it was 1. The level is taken in the cycle in which the first even event since the last tick arrives. Odd events alone have no effect in this mode.
- R6: `count` changes only on the edge of a cycle in which `tick` is high. Any number of events of one channel between two ticks give at most one step. An event in the tick cycle itself is included in that tick.
- R7: A step up from all-ones wraps `count` to 0 and sets `ovf`. `ovf` stays set through later steps until a `clr_ovf` pulse clears it.
- R8: A step down from 0 wraps `count` to all-ones and sets `unf`. `unf` stays set until a `clr_unf` pulse clears it.
- R9: `irq` is high exactly when `irq_en` is 1 and at least one of `ovf` and `unf` is set.
- R10: While `enable` is 0, or while `mode` = 2'b00, `count` holds its value. Events that arrive while `enable` is 0 are discarded and are not applied after `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer enable; low holds the count and drops pending events |
| mode | input | 2 | Counting rule: 00 off, 01 up, 10 up/down, 11 rotary |
| tick | input | 1 | Prescaled tick strobe |
| even_evt | input | 1 | Qualified event on the even channel |
| odd_evt | input | 1 | Qualified event on the odd channel |
| odd_level | input | 1 | Level of the odd channel input |
| irq_en | input | 1 | Interrupt enable |
| clr_ovf | input | 1 | Write-1 clear of the overflow flag |
| clr_unf | input | 1 | Write-1 clear of the underflow flag |
| count | output | WIDTH | Net event count |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the counter with `WIDTH` = 4 instead of the default 16. With that width, wrapping past all-ones and below zero takes only a few ticks, so the sticky flags, their clears and the interrupt gating are all reached by short directed sequences. The counting rules do not depend on the width, so the same sequences also check the up, up/down and rotary decoding, the holding of events between ticks, and the cancelling of simultaneous events.

// File: rtl/paired_event_counter.sv
module paired_event_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             tick,
  input  logic             even_evt,
  input  logic             odd_evt,
  input  logic             odd_level,
  input  logic             irq_en,
  input  logic             clr_ovf,
  input  logic             clr_unf,
  output logic [WIDTH-1:0] count,
  output logic             ovf,
  output logic             unf,
  output logic             irq
);

  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic ev_hold, od_hold, dir_hold;
  logic ev_seen, od_seen, rot_down;
  logic want_up, want_dn, step_up, step_dn;

  assign ev_seen  = ev_hold | even_evt;
  assign od_seen  = od_hold | odd_evt;
  assign rot_down = ev_hold ? dir_hold : odd_level;

  always_comb begin
    want_up = 1'b0;
    want_dn = 1'b0;
    case (mode)
      2'b01: want_up = ev_seen;
      2'b10: begin
        want_up = ev_seen & ~od_seen;
        want_dn = od_seen & ~ev_seen;
      end
      2'b11: begin
        want_up = ev_seen & ~rot_down;
        want_dn = ev_seen & rot_down;
      end
      default: ;
    endcase
  end

  assign step_up = enable & tick & want_up;
  assign step_dn = enable & tick & want_dn;

  // pending events wait for the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_hold  <= 1'b0;
      od_hold  <= 1'b0;
      dir_hold <= 1'b0;
    end else if (!enable || tick) begin
      ev_hold  <= 1'b0;
      od_hold  <= 1'b0;
      dir_hold <= 1'b0;
    end else begin
      if (even_evt && !ev_hold) begin
        ev_hold  <= 1'b1;
        dir_hold <= odd_level;
      end
      if (odd_evt) od_hold <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (step_up) count <= count + ONE;
    else if (step_dn) count <= count - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (step_up && count == TOP) ovf <= 1'b1;
      else if (clr_ovf)            ovf <= 1'b0;
      if (step_dn && count == '0)  unf <= 1'b1;
      else if (clr_unf)            unf <= 1'b0;
    end
  end

  assign irq = irq_en & (ovf | unf);

  // R6: count only moves on a tick edge
  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  // R10: disabled or off mode holds the count
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || mode == 2'b00) |=> $stable(count));
  // R7: overflow rises only on a wrap to zero
  a_r7_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(count) == TOP && count == '0));
  // R8: underflow rises only on a wrap to all-ones
  a_r8_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf) |-> ($past(count) == '0 && count == TOP));
  // R9: no request without enable
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  // R4: both pending in up/down mode means no step
  a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ev_seen && od_seen) |=> $stable(count));

endmodule

// File: tb/paired_event_counter_test.sv
module paired_event_counter_test;
  localparam int PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic tick = 1'b0, even_evt = 1'b0, odd_evt = 1'b0, odd_level = 1'b0;
  logic irq_en = 1'b0, clr_ovf = 1'b0, clr_unf = 1'b0;
  logic [W-1:0] count;
  logic ovf, unf, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  paired_event_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .tick(tick),
    .even_evt(even_evt), .odd_evt(odd_evt), .odd_level(odd_level),
    .irq_en(irq_en), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
    .count(count), .ovf(ovf), .unf(unf), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle at a negedge, then wait for the next negedge
  task automatic cyc(input bit e, input bit o, input bit l, input bit t);
    even_evt = e; odd_evt = o; odd_level = l; tick = t;
    @(negedge clk);
    even_evt = 0; odd_evt = 0; tick = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    enable = 0; cyc(0, 0, 0, 0);
    mode = m; cyc(0, 0, 0, 0);
    enable = 1; cyc(0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 unf", unf, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_up;
    set_mode(2'b01);
    cyc(1, 0, 0, 0); chk("R6 no tick yet", count, 0);
    cyc(0, 0, 0, 1); chk("R2 up step", count, 1);
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); chk("R2 odd ignored", count, 1);
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); cyc(0, 0, 0, 1);
    chk("R6 one step per tick", count, 2);
    cyc(0, 0, 0, 1); chk("R6 idle tick", count, 2);
    cyc(1, 0, 0, 1); chk("R6 event on tick cycle", count, 3);
  endtask

  task automatic t_updown;
    set_mode(2'b10);
    chk("R10 mode change keeps count", count, 3);
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 1); chk("R3 up", count, 4);
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); chk("R3 down", count, 3);
    cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); cyc(0, 0, 0, 1);
    chk("R4 split cancel", count, 3);
    cyc(1, 1, 0, 1); chk("R4 same-cycle cancel", count, 3);
  endtask

  task automatic t_rotary;
    set_mode(2'b11);
    cyc(1, 0, 0, 0); cyc(0, 0, 0, 1); chk("R5 level 0 up", count, 4);
    cyc(1, 0, 1, 0); cyc(0, 0, 1, 1); chk("R5 level 1 down", count, 3);
    cyc(1, 0, 1, 0); cyc(0, 0, 0, 1); chk("R5 level latched", count, 2);
    cyc(0, 1, 0, 0); cyc(0, 0, 0, 1); chk("R5 odd ignored", count, 2);
  endtask

  task automatic t_disable;
    enable = 0;
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 1); chk("R10 disabled hold", count, 2);
    cyc(1, 0, 0, 0);
    enable = 1;
    cyc(0, 0, 0, 1); chk("R10 events dropped", count, 2);
    set_mode(2'b00);
    cyc(1, 0, 0, 1); chk("R10 off mode", count, 2);
  endtask

  task automatic t_wrap;
    set_mode(2'b01);
    for (int i = 0; i < 13; i++) cyc(1, 0, 0, 1);
    chk("R7 at top", count, 15);
    chk("R7 no early ovf", ovf, 0);
    cyc(1, 0, 0, 1);
    chk("R7 wrap to zero", count, 0);
    chk("R7 ovf set", ovf, 1);
    chk("R9 irq masked", irq, 0);
    irq_en = 1; cyc(0, 0, 0, 0);
    chk("R9 irq raised", irq, 1);
    cyc(1, 0, 0, 1); chk("R7 ovf sticky", ovf, 1);
    clr_ovf = 1; cyc(0, 0, 0, 0); clr_ovf = 0;
    chk("R7 ovf cleared", ovf, 0);
    chk("R9 irq dropped", irq, 0);
    set_mode(2'b10);
    cyc(0, 1, 0, 1); chk("R3 down to zero", count, 0);
    chk("R8 no early unf", unf, 0);
    cyc(0, 1, 0, 1);
    chk("R8 wrap to top", count, 15);
    chk("R8 unf set", unf, 1);
    chk("R9 irq on unf", irq, 1);
    clr_unf = 1; cyc(0, 0, 0, 0); clr_unf = 0;
    chk("R8 unf cleared", unf, 0);
    chk("R9 irq idle", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_up;
    t_updown;
    t_rotary;
    t_disable;
    t_wrap;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule